// File: doc/BRIEF.md
# Coincidence and Veto Logic Unit

This unit watches several one-bit hit lines. Each line is the output of a discriminator on a detector channel and has already been brought into the clock domain. When enough enabled channels fire close together in time, and no anti-coincidence signal fires in that time, the unit reports an event. To do this, each rising edge holds its channel's level high for a programmable number of clock cycles. An event is called when the number of stretched channels reaches a programmable multiplicity. A narrow stretch lowers the rate of chance coincidences. A wide stretch catches more hits that arrive with a spread in time.

A veto seen while the coincidence window is open cancels the event. In that case a vetoed counter advances and no output pulse is produced. An accepted event produces a one-cycle pulse. It then starts a programmable dead time. Hits that arrive during the dead time are dropped, and each dropped hit is counted, so the losses can be corrected later. All three counters stop at their largest value and are cleared together by a synchronous clear input.

Top module: `coinc_veto_unit`

## Requirements
- R1: After reset, `event_pulse` is low and all three counters read zero. A high `clr` at a clock edge sets all three counters to zero, and this takes priority over any increment at that edge.
- R2: A rising edge on an enabled channel, sampled at clock edge k, keeps that channel counted at edges k to k+W-1, where W is `win_len`. A `win_len` of 0 acts as 1. Two channels therefore coincide when their rising edges are sampled less than W edges apart.
- R3: An event is decided at the first edge where the number of counted channels is at least `min_mult`, with values below 2 treated as 2. A channel whose bit in `chan_en` is 0 never counts and never opens a window.
- R4: An accepted event drives `event_pulse` high for exactly the one cycle that follows the deciding edge, and adds one to `acc_count`.
- R5: A decision is vetoed when `veto_in` is high at the deciding edge, or at any earlier edge at which some channel was counted since the window opened. A vetoed decision gives no pulse and adds one to `veto_count`. A veto sampled while no channel is counted has no effect.
- R6: Every decision, whether accepted or vetoed, ends the window: all stretched levels are dropped. A line held high does not trigger again until it has gone low and risen once more.
- R7: After an accepted event at edge k, the next `dead_len` edges ignore hits. Each enabled rising edge sampled in that period adds one to `lost_count`. A vetoed decision, or a `dead_len` of 0, starts no dead time.
- R8: Each counter stops at all-ones and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the three counters |
| hit_in | input | N | Synchronised discriminator levels, one per channel |
| veto_in | input | 1 | Anti-coincidence level |
| chan_en | input | N | Per-channel enable mask |
| min_mult | input | $clog2(N+1) | Required multiplicity (values below 2 act as 2) |
| win_len | input | WW | Coincidence window in cycles (0 acts as 1) |
| dead_len | input | DW | Dead time in cycles after an accepted event |
| event_pulse | output | 1 | One-cycle pulse per accepted event |
| acc_count | output | CW | Accepted events, saturating |
| veto_count | output | CW | Vetoed decisions, saturating |
| lost_count | output | CW | Enabled hits dropped during dead time, saturating |

## Verification
The directed tests place pairs of hits exactly W-1 and exactly W edges apart. These two cases show whether the window boundary is counted inclusively. Further directed tests vary the mask and the multiplicity. They also check the rule that a setting below 2 is raised to 2. Each of these has its own pass and fail pattern, so the decision rule can be told apart from a plain OR or AND of the lines.

Veto timing is tested in three positions: before any window, inside an open window, and at the deciding edge. These show whether the veto is remembered for the whole window. Hits are placed on the first and on the last dead edge and then on the edge just after, which fixes the exact length of the dead time.

A long random run with sparse hits and settings that change from time to time is compared each cycle against a bench model. Finally, hammering all channels during a long dead time drives the lost counter into saturation.

// File: rtl/coinc_veto_unit.sv
module coinc_veto_unit #(
  parameter int N  = 4,
  parameter int WW = 8,
  parameter int DW = 8,
  parameter int CW = 16,
  localparam int MW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [N-1:0]  hit_in,
  input  logic          veto_in,
  input  logic [N-1:0]  chan_en,
  input  logic [MW-1:0] min_mult,
  input  logic [WW-1:0] win_len,
  input  logic [DW-1:0] dead_len,
  output logic          event_pulse,
  output logic [CW-1:0] acc_count,
  output logic [CW-1:0] veto_count,
  output logic [CW-1:0] lost_count
);

  function automatic logic [MW-1:0] pop(input logic [N-1:0] v);
    logic [MW-1:0] s;
    s = '0;
    for (int i = 0; i < N; i++) s = s + {{(MW-1){1'b0}}, v[i]};
    return s;
  endfunction

  logic [N-1:0]         hit_q;
  logic [N-1:0][WW-1:0] str;
  logic [DW-1:0]        dead_ctr;
  logic                 veto_seen;

  logic [N-1:0]  rise, str_nz, lvl;
  logic [MW-1:0] min_eff;
  logic [WW-1:0] win_eff;
  logic          busy, decide, vetoed, accept;
  logic [CW:0]   lost_sum;

  assign busy    = dead_ctr != '0;
  assign rise    = hit_in & ~hit_q & chan_en;
  assign lvl     = (rise & {N{~busy}}) | str_nz;
  assign min_eff = (min_mult < MW'(2)) ? MW'(2) : min_mult;
  assign win_eff = (win_len == '0) ? WW'(1) : win_len;
  assign decide  = pop(lvl) >= min_eff;
  assign vetoed  = decide & (veto_in | veto_seen);
  assign accept  = decide & ~vetoed;
  assign lost_sum = {1'b0, lost_count} + {{(CW+1-MW){1'b0}}, pop(rise & {N{busy}})};

  always_comb
    for (int i = 0; i < N; i++) str_nz[i] = str[i] != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q     <= '0;
      str       <= '0;
      dead_ctr  <= '0;
      veto_seen <= 1'b0;
      event_pulse <= 1'b0;
    end else begin
      hit_q <= hit_in;
      for (int i = 0; i < N; i++) begin
        if (decide)                 str[i] <= '0;
        else if (rise[i] && !busy)  str[i] <= win_eff - 1'b1;
        else if (str_nz[i])         str[i] <= str[i] - 1'b1;
      end
      if (accept)    dead_ctr <= dead_len;
      else if (busy) dead_ctr <= dead_ctr - 1'b1;
      veto_seen   <= !decide && (|lvl) && (veto_seen || veto_in);
      event_pulse <= accept;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_count  <= '0;
      veto_count <= '0;
      lost_count <= '0;
    end else if (clr) begin
      acc_count  <= '0;
      veto_count <= '0;
      lost_count <= '0;
    end else begin
      if (accept && !(&acc_count))  acc_count  <= acc_count + 1'b1;
      if (vetoed && !(&veto_count)) veto_count <= veto_count + 1'b1;
      lost_count <= lost_sum[CW] ? {CW{1'b1}} : lost_sum[CW-1:0];
    end
  end

endmodule

// File: rtl/coinc_veto_chk.sv
module coinc_veto_chk #(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          veto_in,
  input logic [DW-1:0] dead_len,
  input logic          event_pulse,
  input logic [CW-1:0] acc_count,
  input logic [CW-1:0] veto_count,
  input logic [CW-1:0] lost_count
);

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_count == '0) && (veto_count == '0) && (lost_count == '0));

  p_pulse_counts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (event_pulse && !$past(clr)) |-> ((acc_count == $past(acc_count) + 1'b1) || (&acc_count)));

  p_veto_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(veto_in) |-> !event_pulse);

  p_accept_not_vetoed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (event_pulse && !$past(clr)) |-> (veto_count == $past(veto_count)));

  p_dead_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (event_pulse && ($past(dead_len) != '0)) |=> !event_pulse);

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (acc_count >= $past(acc_count)) && (veto_count >= $past(veto_count))
             && (lost_count >= $past(lost_count)));

endmodule

bind coinc_veto_unit coinc_veto_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .veto_in(veto_in), .dead_len(dead_len),
  .event_pulse(event_pulse), .acc_count(acc_count), .veto_count(veto_count),
  .lost_count(lost_count)
);

// File: tb/coinc_veto_unit_bench.sv
module coinc_veto_unit_bench;
  localparam int N = 4, WW = 8, DW = 8, CW = 8, MW = $clog2(N + 1);
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, clr = 0, veto_in = 0;
  logic [N-1:0] hit_in = '0, chan_en = '1;
  logic [MW-1:0] min_mult = 2;
  logic [WW-1:0] win_len = 4;
  logic [DW-1:0] dead_len = 5;
  logic event_pulse;
  logic [CW-1:0] acc_count, veto_count, lost_count;

  int errs = 0, checks = 0;
  bit done = 0;

  coinc_veto_unit #(.N(N), .WW(WW), .DW(DW), .CW(CW)) u_coinc_veto_unit (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hit_in(hit_in), .veto_in(veto_in),
    .chan_en(chan_en), .min_mult(min_mult), .win_len(win_len), .dead_len(dead_len),
    .event_pulse(event_pulse), .acc_count(acc_count), .veto_count(veto_count),
    .lost_count(lost_count));

  always #5 clk = ~clk;

  // reference model state
  bit [N-1:0] m_hq;
  int m_rem [N];
  int m_dead, m_acc, m_vet, m_lost;
  bit m_vs, m_pulse;

  task automatic model_reset();
    m_hq = '0; m_dead = 0; m_acc = 0; m_vet = 0; m_lost = 0; m_vs = 0; m_pulse = 0;
    for (int i = 0; i < N; i++) m_rem[i] = 0;
  endtask

  function automatic int sat(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic model_step();
    bit busy, dec, vet, acc, any;
    int cnt, need, w, nlost;
    busy = m_dead > 0;
    cnt = 0; any = 0; nlost = 0;
    for (int i = 0; i < N; i++) begin
      bit r, l;
      r = hit_in[i] && !m_hq[i] && chan_en[i];
      l = (r && !busy) || (m_rem[i] > 0);
      if (l) begin cnt++; any = 1; end
      if (r && busy) nlost++;
    end
    need = (min_mult < 2) ? 2 : int'(min_mult);
    dec = cnt >= need;
    vet = dec && (veto_in || m_vs);
    acc = dec && !vet;
    w = (win_len == 0) ? 1 : int'(win_len);
    for (int i = 0; i < N; i++) begin
      bit r;
      r = hit_in[i] && !m_hq[i] && chan_en[i];
      if (dec) m_rem[i] = 0;
      else if (r && !busy) m_rem[i] = w - 1;
      else if (m_rem[i] > 0) m_rem[i]--;
    end
    if (acc) m_dead = int'(dead_len);
    else if (busy) m_dead--;
    m_vs = !dec && any && (m_vs || veto_in);
    if (clr) begin m_acc = 0; m_vet = 0; m_lost = 0; end
    else begin
      m_acc = sat(m_acc + int'(acc));
      m_vet = sat(m_vet + int'(vet));
      m_lost = sat(m_lost + nlost);
    end
    m_pulse = acc;
    m_hq = hit_in;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, step model at posedge, compare at the next negedge
  task automatic cyc(input logic [N-1:0] h, input logic v);
    hit_in = h; veto_in = v;
    @(posedge clk);
    model_step();
    @(negedge clk);
    checks++;
    if (event_pulse !== m_pulse || acc_count != m_acc || veto_count != m_vet || lost_count != m_lost) begin
      errs++;
      $display("FAIL model R4 R5 R7: actual p=%0b a=%0d v=%0d l=%0d expected p=%0b a=%0d v=%0d l=%0d",
               event_pulse, acc_count, veto_count, lost_count, m_pulse, m_acc, m_vet, m_lost);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc('0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int a0, v0, l0;
    void'($urandom(32'h1234));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset pulse", int'(event_pulse), 0);
    chk("R1 reset acc", int'(acc_count), 0);
    chk("R1 reset lost", int'(lost_count) + int'(veto_count), 0);
    rst_n = 1;
    idle(2);

    // R2: window boundary, W=4
    a0 = m_acc;
    cyc(4'b0001, 0); idle(2); cyc(4'b0010, 0);
    chk("R4 pulse on edge W-1 apart", int'(event_pulse), 1);
    cyc('0, 0);
    chk("R4 pulse one cycle", int'(event_pulse), 0);
    chk("R2 inside window", int'(acc_count) - a0, 1);
    idle(8);
    a0 = int'(acc_count);
    cyc(4'b0001, 0); idle(3); cyc(4'b0010, 0); idle(6);
    chk("R2 outside window", int'(acc_count) - a0, 0);

    // R3: mask and multiplicity
    chan_en = 4'b1110;
    cyc(4'b0011, 0); idle(6);
    chk("R3 masked channel ignored", int'(acc_count) - a0, 0);
    chan_en = '1; min_mult = 3;
    cyc(4'b0011, 0); idle(5);
    chk("R3 below multiplicity", int'(acc_count) - a0, 0);
    cyc(4'b0111, 0); idle(8);
    chk("R3 at multiplicity", int'(acc_count) - a0, 1);
    min_mult = 0;
    cyc(4'b1100, 0); idle(8);
    chk("R3 low setting acts as 2", int'(acc_count) - a0, 2);
    min_mult = 2;

    // R5: veto positions
    a0 = int'(acc_count); v0 = int'(veto_count);
    cyc('0, 1); cyc(4'b0001, 0); cyc('0, 1); cyc(4'b0010, 0);
    chk("R5 veto in window no pulse", int'(event_pulse), 0);
    chk("R5 veto counted", int'(veto_count) - v0, 1);
    cyc(4'b1100, 0);
    chk("R5 R7 no dead after veto", int'(acc_count) - a0, 1);
    idle(8);
    cyc(4'b0011, 1);
    chk("R5 veto at deciding edge", int'(veto_count) - v0, 2);
    idle(6);

    // R6: windows dropped after decision, held line does not retrigger
    dead_len = 0; a0 = int'(acc_count);
    cyc(4'b0011, 0); cyc(4'b0101, 0); cyc(4'b0001, 0); cyc(4'b0001, 0);
    chk("R6 stretches cleared", int'(acc_count) - a0, 1);
    idle(6);

    // R7: dead time length and lost hits
    dead_len = 5; a0 = int'(acc_count); l0 = int'(lost_count);
    cyc(4'b0011, 0); cyc(4'b1100, 0); cyc('0, 0); cyc(4'b0001, 0); cyc('0, 0);
    cyc(4'b0110, 0);
    chk("R7 lost during dead", int'(lost_count) - l0, 5);
    chk("R7 no event during dead", int'(acc_count) - a0, 1);
    cyc(4'b1001, 0);
    chk("R7 live after dead", int'(acc_count) - a0, 2);
    idle(8);

    // R8: saturation of lost counter
    dead_len = 255; win_len = 1;
    cyc('1, 0);
    for (int i = 0; i < 140; i++) begin cyc('0, 0); cyc('1, 0); end
    chk("R8 lost saturates", int'(lost_count), CMAX);
    cyc('0, 0); cyc('1, 0);
    chk("R8 stays at max", int'(lost_count), CMAX);
    clr = 1; cyc('0, 0); clr = 0;
    chk("R1 clear", int'(lost_count) + int'(acc_count) + int'(veto_count), 0);
    dead_len = 0; idle(300);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [N-1:0] h;
      if ($urandom_range(0, 199) == 0) begin
        win_len  = WW'($urandom_range(0, 8));
        min_mult = MW'($urandom_range(0, 4));
        dead_len = DW'($urandom_range(0, 10));
        chan_en  = N'($urandom_range(1, 15));
      end
      clr = ($urandom_range(0, 499) == 0);
      for (int i = 0; i < N; i++) h[i] = ($urandom_range(0, 5) == 0);
      cyc(h, $urandom_range(0, 9) == 0);
    end
    clr = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule